// File: doc/BRIEF.md
# Floating-Point Status Word and Conditional-Move Unit

This unit owns the 16-bit status word of a stack-based floating-point engine. It turns the outcome of a floating compare, delivered as integer-style zero, parity and carry flags, into the four condition-code bits of the word. On request, it also issues a pop strobe to the stack controller together with the compare. A status read returns the word with the live top-of-stack pointer spliced into its pointer field. Three commands act on the word: a clear command wipes the exception and busy bits, a condition-clear command resets C1 and C2 for non-compare arithmetic, and a load command replaces the whole word.

A second, purely combinational path evaluates the floating conditional-move predicates. It uses a two-bit condition selector and an invert control, reads the integer flags, and picks either the relative-register operand or the current top operand. The number comparison itself and the production of the flags take place upstream.

Bit layout of the word, from bit 15 down: busy (15), C3 (14), pointer field (13:11), C2 (10), C1 (9), C0 (8), error summary (7), stack fault (6), then the six exception bits in 5:0.

Top module: `fsw_unit`

## Requirements
- R1: After reset the stored word is 0x0000, and both `pop_strobe` and `rd_vld` are low.
- R2: A compare request writes C3 (bit 14) from ZF, C2 (bit 10) from PF and C0 (bit 8) from CF, and forces C1 (bit 9) to 0. It leaves bits 15, 13:11 and 7:0 unchanged.
- R3: The four compare outcomes produce these condition codes C3..C0: greater (all flags 0) gives 0000; less (CF) gives 0001; equal (ZF) gives 1000; unordered (ZF, PF, CF) gives 1101.
- R4: A read request makes `rd_vld` high in the next cycle. In that cycle `rd_word` holds the stored word as it was in the request cycle, with bits 13:11 replaced by `top_ptr` as sampled in the request cycle.
- R5: The exception-clear command zeroes bits 7:0 and bit 15 and keeps bits 14 and 13:8.
- R6: The condition-clear command zeroes C1 and C2. When a compare arrives in the same cycle, the compare's values are written instead.
- R7: A load writes `ld_word` into the whole word in the next cycle. It overrides compare, exception clear and condition clear in the same cycle, and it suppresses the pop strobe.
- R8: A compare request with `cmp_pop` set raises `pop_strobe` for exactly the one cycle in which the new condition codes first appear in the word.
- R9: Condition selector `mv_op` encodings: 0 takes on CF, 1 on ZF, 2 on ZF or CF, 3 on PF.
- R10: When `mv_inv` is high, each predicate is inverted.
- R11: When the predicate holds, `mv_result` equals `opnd_rel` and `mv_take` is 1. Otherwise `mv_result` equals `opnd_top` and `mv_take` is 0.
- R12: An exception clear and a compare in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Compare result present |
| cmp_zf | input | 1 | Compare zero flag |
| cmp_pf | input | 1 | Compare parity (unordered) flag |
| cmp_cf | input | 1 | Compare carry (less) flag |
| cmp_pop | input | 1 | Compare also pops the stack |
| cc_clr | input | 1 | Clear C1 and C2 (non-compare operation) |
| exc_clr | input | 1 | Clear exception and busy bits |
| ld_en | input | 1 | Load the whole word |
| ld_word | input | 16 | Word to load |
| rd_req | input | 1 | Status read request |
| top_ptr | input | 3 | Live top-of-stack pointer |
| rd_vld | output | 1 | Read data valid |
| rd_word | output | 16 | Status word with pointer spliced in |
| pop_strobe | output | 1 | Pop request to stack controller |
| mv_op | input | 2 | Conditional-move predicate selector |
| mv_inv | input | 1 | Invert predicate |
| fl_zf | input | 1 | Integer zero flag |
| fl_pf | input | 1 | Integer parity flag |
| fl_cf | input | 1 | Integer carry flag |
| opnd_top | input | 64 | Current top-of-stack operand |
| opnd_rel | input | 64 | Relative-register operand |
| mv_take | output | 1 | Predicate holds |
| mv_result | output | 64 | Selected operand |

## Verification
The assertions assume that the command inputs are at known levels whenever reset is released and that `ld_en` takes priority. The pointer check also assumes that `top_ptr` is stable for the whole request cycle. The bench changes inputs only on the falling edge, so every command is held across a full rising edge. It deliberately drives colliding commands (load with compare, clear with compare, condition clear with compare) so that the priority cases are exercised as well as the single-command cases.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    localparam int SW_W    = 16;
    localparam int PTR_W   = 3;
    localparam int PTR_LO  = 11;
    localparam int PTR_HI  = PTR_LO + PTR_W - 1;
    localparam int B_BUSY  = 15;
    localparam int B_C3    = 14;
    localparam int B_C2    = 10;
    localparam int B_C1    = 9;
    localparam int B_C0    = 8;
    localparam int EXC_HI  = 7;

    typedef enum logic [1:0] {
        PRED_BELOW = 2'd0,
        PRED_EQUAL = 2'd1,
        PRED_BE    = 2'd2,
        PRED_UNORD = 2'd3
    } pred_e;

    typedef struct packed {
        logic [3:0] cc; // {C3, C2, C1, C0}
    } cc_t;

    typedef struct packed {
        logic [SW_W-1:0] word;
        logic            pop;
        logic            rd_vld;
        logic [SW_W-1:0] rd_word;
    } fsw_state_t;
endpackage

// File: rtl/fsw_cc_map.sv
module fsw_cc_map
    import fsw_pkg::*;
(
    input  logic zf,
    input  logic pf,
    input  logic cf,
    output cc_t  cc
);
    always_comb begin
        cc.cc[3] = zf;
        cc.cc[2] = pf;
        cc.cc[1] = 1'b0;
        cc.cc[0] = cf;
    end
endmodule

// File: rtl/fsw_cmov.sv
module fsw_cmov
    import fsw_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        op,
    input  logic              inv,
    input  logic              zf,
    input  logic              pf,
    input  logic              cf,
    input  logic [DATA_W-1:0] top,
    input  logic [DATA_W-1:0] rel,
    output logic              take,
    output logic [DATA_W-1:0] res
);
    logic raw_pred;

    always_comb begin
        unique case (pred_e'(op))
            PRED_BELOW: raw_pred = cf;
            PRED_EQUAL: raw_pred = zf;
            PRED_BE:    raw_pred = zf | cf;
            PRED_UNORD: raw_pred = pf;
            default:    raw_pred = 1'b0;
        endcase
        take = raw_pred ^ inv;
        res  = take ? rel : top;
    end

    AST_PRED_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1) |-> (take == (zf ^ inv))); // R9
    AST_PRED_BE_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd2 && inv) |-> (take == !(zf || cf))); // R10
    AST_SEL_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rel != top) |-> (res != top)); // R11
endmodule

// File: rtl/fsw_unit.sv
module fsw_unit
    import fsw_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic              cmp_zf,
    input  logic              cmp_pf,
    input  logic              cmp_cf,
    input  logic              cmp_pop,
    input  logic              cc_clr,
    input  logic              exc_clr,
    input  logic              ld_en,
    input  logic [15:0]       ld_word,
    input  logic              rd_req,
    input  logic [2:0]        top_ptr,
    output logic              rd_vld,
    output logic [15:0]       rd_word,
    output logic              pop_strobe,
    input  logic [1:0]        mv_op,
    input  logic              mv_inv,
    input  logic              fl_zf,
    input  logic              fl_pf,
    input  logic              fl_cf,
    input  logic [DATA_W-1:0] opnd_top,
    input  logic [DATA_W-1:0] opnd_rel,
    output logic              mv_take,
    output logic [DATA_W-1:0] mv_result
);
    fsw_state_t st_d, st_q;
    cc_t        cmp_cc;
    logic [SW_W-1:0] sw_q;

    fsw_cc_map u_cc_map (
        .zf (cmp_zf),
        .pf (cmp_pf),
        .cf (cmp_cf),
        .cc (cmp_cc)
    );

    fsw_cmov #(.DATA_W(DATA_W)) u_cmov (
        .clk  (clk),
        .rst_n(rst_n),
        .op   (mv_op),
        .inv  (mv_inv),
        .zf   (fl_zf),
        .pf   (fl_pf),
        .cf   (fl_cf),
        .top  (opnd_top),
        .rel  (opnd_rel),
        .take (mv_take),
        .res  (mv_result)
    );

    always_comb begin
        st_d        = st_q;
        st_d.pop    = cmp_valid & cmp_pop & ~ld_en;
        st_d.rd_vld = rd_req;
        st_d.rd_word = st_q.word;
        st_d.rd_word[PTR_HI:PTR_LO] = top_ptr;
        if (ld_en) begin
            st_d.word = ld_word;
        end else begin
            if (exc_clr) begin
                st_d.word[B_BUSY]   = 1'b0;
                st_d.word[EXC_HI:0] = '0;
            end
            if (cmp_valid) begin
                st_d.word[B_C3] = cmp_cc.cc[3];
                st_d.word[B_C2] = cmp_cc.cc[2];
                st_d.word[B_C1] = cmp_cc.cc[1];
                st_d.word[B_C0] = cmp_cc.cc[0];
            end else if (cc_clr) begin
                st_d.word[B_C2] = 1'b0;
                st_d.word[B_C1] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sw_q       = st_q.word;
    assign rd_vld     = st_q.rd_vld;
    assign rd_word    = st_q.rd_word;
    assign pop_strobe = st_q.pop;

    AST_CMP_C1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !ld_en) |=> !sw_q[B_C1]); // R2
    AST_CMP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !ld_en) |=> (sw_q[B_C3] == $past(cmp_zf) && sw_q[B_C2] == $past(cmp_pf)
                                   && sw_q[B_C0] == $past(cmp_cf))); // R2
    AST_EXC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_clr && !ld_en) |=> (sw_q[EXC_HI:0] == '0 && !sw_q[B_BUSY])); // R5
    AST_EXC_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_clr && !ld_en && !cmp_valid && !cc_clr) |=> $stable(sw_q[14:8])); // R5
    AST_POP_WITH_CC: assert property (@(posedge clk) disable iff (!rst_n)
        pop_strobe |-> !sw_q[B_C1]); // R8
    AST_RD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> (rd_word[PTR_HI:PTR_LO] == $past(top_ptr))); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (sw_q == $past(ld_word) && !pop_strobe)); // R7
endmodule

// File: tb/fsw_unit_bench.sv
`timescale 1ns/1ps
module fsw_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic cmp_valid, cmp_zf, cmp_pf, cmp_cf, cmp_pop, cc_clr, exc_clr, ld_en, rd_req;
    logic [15:0] ld_word;
    logic [2:0]  top_ptr;
    logic        rd_vld, pop_strobe, mv_take, mv_inv, fl_zf, fl_pf, fl_cf;
    logic [15:0] rd_word;
    logic [1:0]  mv_op;
    logic [63:0] opnd_top, opnd_rel, mv_result;

    fsw_unit u_fsw_unit (
        .clk(clk), .rst_n(rst_n),
        .cmp_valid(cmp_valid), .cmp_zf(cmp_zf), .cmp_pf(cmp_pf), .cmp_cf(cmp_cf),
        .cmp_pop(cmp_pop), .cc_clr(cc_clr), .exc_clr(exc_clr),
        .ld_en(ld_en), .ld_word(ld_word), .rd_req(rd_req), .top_ptr(top_ptr),
        .rd_vld(rd_vld), .rd_word(rd_word), .pop_strobe(pop_strobe),
        .mv_op(mv_op), .mv_inv(mv_inv), .fl_zf(fl_zf), .fl_pf(fl_pf), .fl_cf(fl_cf),
        .opnd_top(opnd_top), .opnd_rel(opnd_rel), .mv_take(mv_take), .mv_result(mv_result)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [15:0] m_word = 16'h0000;
    logic        e_pop = 1'b0;
    logic        e_vld = 1'b0;
    logic [15:0] e_rd  = 16'h0000;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cmp_valid = 0; cmp_zf = 0; cmp_pf = 0; cmp_cf = 0; cmp_pop = 0;
        cc_clr = 0; exc_clr = 0; ld_en = 0; ld_word = 16'h0; rd_req = 0;
    endtask

    // one clock: drive at falling edge, model at rising edge, check at next falling edge
    task automatic step(input string req, input logic ld, input logic [15:0] lw,
                        input logic cv, input logic [2:0] zpc, input logic pp,
                        input logic ec, input logic cc, input logic rr, input logic [2:0] tp);
        ld_en = ld; ld_word = lw; cmp_valid = cv;
        cmp_zf = zpc[2]; cmp_pf = zpc[1]; cmp_cf = zpc[0]; cmp_pop = pp;
        exc_clr = ec; cc_clr = cc; rd_req = rr; top_ptr = tp;
        @(posedge clk);
        e_pop = cv && pp && !ld;
        e_vld = rr;
        e_rd  = {m_word[15:14], tp, m_word[10:0]};
        if (ld) m_word = lw;
        else begin
            if (ec) begin m_word[15] = 0; m_word[7:0] = 8'h00; end
            if (cv) begin
                m_word[14] = zpc[2]; m_word[10] = zpc[1]; m_word[9] = 0; m_word[8] = zpc[0];
            end else if (cc) begin
                m_word[10] = 0; m_word[9] = 0;
            end
        end
        @(negedge clk);
        idle_inputs();
        chk({req, " pop"}, pop_strobe, e_pop);
        chk({req, " vld"}, rd_vld, e_vld);
        if (e_vld) chk({req, " word"}, rd_word, e_rd);
    endtask

    task automatic rd(input string req, input logic [2:0] tp);
        step(req, 0, 16'h0, 0, 3'b000, 0, 0, 0, 1, tp);
    endtask

    initial begin
        idle_inputs();
        top_ptr = 3'd0; mv_op = 2'd0; mv_inv = 0; fl_zf = 0; fl_pf = 0; fl_cf = 0;
        opnd_top = 64'h1111_2222_3333_4444; opnd_rel = 64'hAAAA_BBBB_CCCC_DDDD;
        repeat (3) @(negedge clk);
        chk("R1 pop at reset", pop_strobe, 0);
        chk("R1 vld at reset", rd_vld, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd("R1 R4 reset word", 3'd6);
        // R7 load then read with pointer splice (R4)
        step("R7 load", 1, 16'hC7FF, 0, 3'b000, 0, 0, 0, 0, 3'd0);
        rd("R4 R7 read after load", 3'd5);
        // R5 exception clear
        step("R5 clear", 0, 16'h0, 0, 3'b000, 0, 1, 0, 0, 3'd0);
        rd("R5 after clear", 3'd2);
        // R3 four compare outcomes, with and without pop (R8)
        step("R3 greater", 0, 16'h0, 1, 3'b000, 1, 0, 0, 0, 3'd0);
        rd("R3 greater rd", 3'd1);
        step("R3 less", 0, 16'h0, 1, 3'b001, 0, 0, 0, 0, 3'd0);
        rd("R3 less rd", 3'd1);
        step("R3 equal", 0, 16'h0, 1, 3'b100, 1, 0, 0, 0, 3'd0);
        rd("R3 equal rd", 3'd7);
        step("R3 R8 unordered pop", 0, 16'h0, 1, 3'b111, 1, 0, 0, 0, 3'd0);
        rd("R3 unordered rd", 3'd3);
        // R2 compare keeps other bits: load background first
        step("R2 setup", 1, 16'hBAFF, 0, 3'b000, 0, 0, 0, 0, 3'd0);
        step("R2 compare", 0, 16'h0, 1, 3'b010, 0, 0, 0, 1, 3'd4);
        rd("R2 after compare", 3'd4);
        // R6 condition clear, then collision with compare
        step("R6 setup", 1, 16'h0700, 0, 3'b000, 0, 0, 0, 0, 3'd0);
        step("R6 cc clear", 0, 16'h0, 0, 3'b000, 0, 0, 1, 0, 3'd0);
        rd("R6 after cc clear", 3'd0);
        step("R6 clear with compare", 0, 16'h0, 1, 3'b111, 0, 0, 1, 0, 3'd0);
        rd("R6 compare wins", 3'd0);
        // R12 exception clear and compare together
        step("R12 setup", 1, 16'h80A5, 0, 3'b000, 0, 0, 0, 0, 3'd0);
        step("R12 both", 0, 16'h0, 1, 3'b001, 1, 1, 0, 0, 3'd0);
        rd("R12 both rd", 3'd6);
        // R7 load overrides compare, clear and pop
        step("R7 override", 1, 16'h1234, 1, 3'b111, 1, 1, 1, 0, 3'd0);
        rd("R7 override rd", 3'd2);
        // R8 pop only with cmp_pop and only one cycle
        step("R8 no pop", 0, 16'h0, 1, 3'b100, 0, 0, 0, 0, 3'd0);
        step("R8 idle after", 0, 16'h0, 0, 3'b000, 0, 0, 0, 0, 3'd0);
        // R9 R10 R11 conditional move, exhaustive
        for (int op = 0; op < 4; op++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int f = 0; f < 8; f++) begin
                    logic pred;
                    mv_op = op[1:0]; mv_inv = iv[0];
                    fl_zf = f[2]; fl_pf = f[1]; fl_cf = f[0];
                    opnd_top = {32'h0, 24'h0, 8'(f)} ^ 64'h0F0F_0000_0000_0000;
                    opnd_rel = {32'hFFFF_0000, 24'h0, 8'(op)};
                    #1;
                    case (op)
                        0: pred = f[0];
                        1: pred = f[2];
                        2: pred = f[2] | f[0];
                        default: pred = f[1];
                    endcase
                    if (iv != 0) pred = !pred;
                    chk(iv != 0 ? "R10 take" : "R9 take", mv_take, pred);
                    chk("R11 result", mv_result, pred ? opnd_rel : opnd_top);
                    @(negedge clk);
                end
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule